// File: doc/BRIEF.md
# Banked Register-Programmed PWM Generator

This block drives a bank of independent pulse-width outputs from one synchronous clock. Each channel has a 4-bit frequency code `F` and a 10-bit duty field `D`, both written through a byte-wide register port. A quantum of time is `32 - F` clock cycles long, so the divider runs from 17 to 32. Every output period is 1024 quanta long, and the output is high for the first `D + 1` quanta of each period. The high time therefore runs from one quantum up to the whole period. A zero duty is reached only by clearing the channel's enable bit. A disabled channel holds its output low.

A host writes the configuration of a channel into its two registers. It then sets the channel's bit in the shared enable register. New duty and frequency values are staged and take effect only when the running period wraps, so an output never shows a shortened or stretched pulse in the middle of a period. Setting an enable bit starts a fresh period whose first quantum is high. Clearing an enable bit drops the output at once and returns the channel's counters to zero. At a 9.6 MHz clock, the frequency codes span roughly 293 Hz to 551 Hz.

Top module: `pwm_bank`

## Requirements
- R1: The synchronous active-high reset `rst` clears every register to zero. While reset is held and after it is released, every output is low and every mapped address reads 0x00.
- R2: Channel n owns a duty-low register at `BASE_ADDR + 2n`, which holds D[7:0], and a duty-high/frequency register at `BASE_ADDR + 2n + 1`, which holds D[9:8] in bits [1:0] and F in bits [7:4]. Both registers read back the last value written, and bits [3:2] of the second register always read as zero.
- R3: A write to an address outside the map (below `BASE_ADDR` or above `BASE_ADDR + 2*N_CH`) changes no register and no output. A read from such an address returns 0x00.
- R4: The enable register sits at `BASE_ADDR + 2*N_CH`, and bit n enables channel n. Bits at or above `N_CH` are not stored and read as zero.
- R5: One quantum lasts `32 - F` clock cycles, and every period lasts exactly 1024 quanta, which is `1024*(32-F)` cycles from one rising edge of the output to the next.
- R6: The output is high for `(D+1)*(32-F)` cycles per period. With D = 1023 the output stays high with no low cycle.
- R7: A channel whose enable bit is zero drives its output low. Clearing the bit takes the output low in the cycle after the write edge, and the channel's prescaler and quantum counters are reset.
- R8: Setting an enable bit starts a new period. The output goes high in the second cycle after the write edge and stays high for a full `(D+1)*(32-F)` cycles.
- R9: Duty and frequency values written while a channel runs leave the current period unchanged and apply from the next period onward.
- R10: Channels run independently, and changing one channel's registers or enable bit does not alter another channel's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which also clocks the prescalers |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writes `wr_data` to `addr` on the rising clock edge |
| addr | input | 8 | Register address for both the write and the read |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| pwm_out | output | N_CH | One PWM output per channel |

## Verification
If a channel's prescaler or quantum counter holds a wrong value, the pulse length measured between output edges is off within one period. That is at most 32768 cycles. A staging register that loads at the wrong moment shows up as a wrong pulse in the period that holds the write, instead of in the next one. Errors in the enable path show at the ports within one or two cycles of the write, as a missed start-high or a missed forced-low. Decode and storage errors show at once on `rd_data`, or as a changed output after a write to an unmapped address.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Field widths of one channel
    localparam int DUTY_W  = 10;
    localparam int FREQ_W  = 4;
    localparam int DIV_W   = 6;
    localparam int DIV_TOP = 32;

    // Configuration of one channel as held in the register file
    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [DUTY_W-1:0] duty;
    } chan_cfg_t;

    // Kinds of register address
    typedef enum logic [1:0] {
        AK_NONE   = 2'd0,
        AK_DUTY_L = 2'd1,
        AK_DUTY_H = 2'd2,
        AK_ENABLE = 2'd3
    } addr_kind_t;

    // Quantum length in clock cycles for a given frequency code
    function automatic logic [DIV_W-1:0] quantum_len(input logic [FREQ_W-1:0] f);
        return DIV_W'(DIV_TOP) - {{(DIV_W-FREQ_W){1'b0}}, f};
    endfunction

    // Readback byte of the duty-high/frequency register
    function automatic logic [7:0] hi_byte(input chan_cfg_t c);
        return {c.freq, 2'b00, c.duty[DUTY_W-1:8]};
    endfunction

endpackage

// File: rtl/pwm_bank_regfile.sv
module pwm_bank_regfile
    import pwm_bank_pkg::*;
#(
    parameter int         N_CH      = 4,
    parameter logic [7:0] BASE_ADDR = 8'h60
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            addr,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    output chan_cfg_t [N_CH-1:0]  cfg,
    output logic [N_CH-1:0]       en_vec
);

    localparam int         IDX_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam logic [7:0] EN_OFF = 8'(2 * N_CH);

    addr_kind_t       kind;
    logic [IDX_W-1:0] idx;
    logic [7:0]       off;

    // Address decode
    always_comb begin
        off  = addr - BASE_ADDR;
        kind = AK_NONE;
        idx  = off[IDX_W:1];
        if (addr >= BASE_ADDR) begin
            if (off < EN_OFF)
                kind = off[0] ? AK_DUTY_H : AK_DUTY_L;
            else if (off == EN_OFF)
                kind = AK_ENABLE;
        end
    end

    // Storage
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            en_vec <= '0;
        end else if (wr_en) begin
            case (kind)
                AK_DUTY_L: cfg[idx].duty[7:0] <= wr_data;
                AK_DUTY_H: begin
                    cfg[idx].duty[DUTY_W-1:8] <= wr_data[1:0];
                    cfg[idx].freq             <= wr_data[7:4];
                end
                AK_ENABLE: en_vec <= wr_data[N_CH-1:0];
                default: ;
            endcase
        end
    end

    // Readback
    always_comb begin
        rd_data = '0;
        case (kind)
            AK_DUTY_L: rd_data = cfg[idx].duty[7:0];
            AK_DUTY_H: rd_data = hi_byte(cfg[idx]);
            AK_ENABLE: rd_data[N_CH-1:0] = en_vec;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm_bank_prescaler.sv
module pwm_bank_prescaler
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = !hold && (cnt == div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || hold)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

endmodule

// File: rtl/pwm_bank_channel.sv
module pwm_bank_channel
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  chan_cfg_t cfg,
    output logic      pwm
);

    logic              run;
    logic              start;
    logic              tick;
    logic              wrap;
    logic [DUTY_W-1:0] quantum;
    logic [DUTY_W-1:0] duty_act;
    logic [DIV_W-1:0]  div_act;

    assign start = en && !run;
    assign wrap  = tick && (quantum == '1);

    pwm_bank_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .hold (!run),
        .div  (div_act),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            quantum  <= '0;
            duty_act <= '0;
            div_act  <= DIV_W'(DIV_TOP);
        end else if (!en) begin
            run     <= 1'b0;
            quantum <= '0;
        end else begin
            run <= 1'b1;
            if (start || wrap) begin
                duty_act <= cfg.duty;
                div_act  <= quantum_len(cfg.freq);
            end
            if (start)
                quantum <= '0;
            else if (tick)
                quantum <= quantum + DUTY_W'(1);
        end
    end

    assign pwm = run && en && (quantum <= duty_act);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int         N_CH      = 4,
    parameter logic [7:0] BASE_ADDR = 8'h60
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [7:0]      addr,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_data,
    output logic [N_CH-1:0] pwm_out
);

    chan_cfg_t [N_CH-1:0] cfg;
    logic [N_CH-1:0]      en_vec;

    pwm_bank_regfile #(
        .N_CH      (N_CH),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg     (cfg),
        .en_vec  (en_vec)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_bank_channel u_ch (
            .clk (clk),
            .rst (rst),
            .en  (en_vec[g]),
            .cfg (cfg[g]),
            .pwm (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int         N_CH      = 4,
    parameter logic [7:0] BASE_ADDR = 8'h60
) (
    input logic            clk,
    input logic            rst,
    input logic [7:0]      addr,
    input logic [7:0]      rd_data,
    input logic [N_CH-1:0] en_vec,
    input logic [N_CH-1:0] pwm_out
);

    localparam logic [7:0] EN_OFF = 8'(2 * N_CH);

    logic [7:0] off;
    logic       mapped;
    assign off    = addr - BASE_ADDR;
    assign mapped = (addr >= BASE_ADDR) && (off <= EN_OFF);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) && !rst |-> (pwm_out == '0) && (en_vec == '0));

    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> rd_data == 8'h00);

    // R2
    hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (mapped && off < EN_OFF && off[0]) |-> rd_data[3:2] == 2'b00);

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        // R7
        dis_low_chk: assert property (@(posedge clk) disable iff (rst)
            !en_vec[g] |-> !pwm_out[g]);
        // R8
        start_high_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(en_vec[g]) |=> pwm_out[g]);
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .N_CH      (N_CH),
    .BASE_ADDR (BASE_ADDR)
) u_pwm_bank_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .rd_data (rd_data),
    .en_vec  (en_vec),
    .pwm_out (pwm_out)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;

    localparam int         NC   = 4;
    localparam logic [7:0] BASE = 8'h60;
    localparam logic [7:0] ENA  = BASE + 8'(2 * NC);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    rd_data;
    logic [NC-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int   hi_len [NC];
    int   per_len[NC];
    int   rises  [NC];
    int   falls  [NC];
    int   last_r [NC];
    logic prev   [NC];

    always #2.5 clk = ~clk;

    pwm_bank #(.N_CH(NC), .BASE_ADDR(BASE)) i_pwm_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor: pulse and period lengths per channel
    initial begin
        for (int c = 0; c < NC; c++) begin
            hi_len[c] = 0; per_len[c] = 0; rises[c] = 0;
            falls[c] = 0; last_r[c] = 0; prev[c] = 1'b0;
        end
        forever begin
            @(negedge clk);
            for (int c = 0; c < NC; c++) begin
                if (pwm_out[c] && !prev[c]) begin
                    if (rises[c] > 0) per_len[c] = cyc - last_r[c];
                    last_r[c] = cyc;
                    rises[c]++;
                end
                if (!pwm_out[c] && prev[c]) begin
                    hi_len[c] = cyc - last_r[c];
                    falls[c]++;
                end
                prev[c] = pwm_out[c];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(v == e, req, v, e);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int r, f;
        logic [7:0] v;
        repeat (4) @(negedge clk);
        chk(pwm_out == '0, "R1 outputs in reset", pwm_out, 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: all mapped registers zero after reset
        for (int a = 0; a <= 2 * NC; a++) rd_chk(BASE + 8'(a), 8'h00, "R1 reset readback");
        chk(pwm_out == '0, "R1 outputs after reset", pwm_out, 0);

        // R2: readback and pad bits
        wr(BASE + 8'd0, 8'hA5);
        wr(BASE + 8'd1, 8'hFF);
        wr(BASE + 8'd3, 8'h0E);
        wr(BASE + 8'd6, 8'h3C);
        wr(BASE + 8'd7, 8'h52);
        rd_chk(BASE + 8'd0, 8'hA5, "R2 duty low ch0");
        rd_chk(BASE + 8'd1, 8'hF3, "R2 high reg ch0 pad");
        rd_chk(BASE + 8'd3, 8'h02, "R2 high reg ch1 pad");
        rd_chk(BASE + 8'd6, 8'h3C, "R2 duty low ch3");
        rd_chk(BASE + 8'd7, 8'h52, "R2 high reg ch3");
        // R4: upper enable bits not stored
        wr(ENA, 8'hF0);
        rd_chk(ENA, 8'h00, "R4 enable upper bits");
        chk(pwm_out == '0, "R4 no output from upper bits", pwm_out, 0);
        // R3: unmapped writes ignored
        wr(BASE - 8'd1, 8'hFF);
        wr(ENA + 8'd1, 8'hFF);
        rd_chk(ENA + 8'd1, 8'h00, "R3 unmapped read high");
        rd_chk(BASE - 8'd1, 8'h00, "R3 unmapped read low");
        rd_chk(BASE + 8'd0, 8'hA5, "R3 ch0 unchanged");
        rd_chk(ENA, 8'h00, "R3 enable unchanged");
        chk(pwm_out == '0, "R3 outputs unchanged", pwm_out, 0);

        // Configure: ch0 F=15 D=99, ch1 F=14 D=1023, ch2 F=0 D=0, ch3 F=15 D=5 off
        wr(BASE + 8'd0, 8'd99);  wr(BASE + 8'd1, 8'hF0);
        wr(BASE + 8'd2, 8'hFF);  wr(BASE + 8'd3, 8'hE3);
        wr(BASE + 8'd4, 8'h00);  wr(BASE + 8'd5, 8'h00);
        wr(BASE + 8'd6, 8'd5);   wr(BASE + 8'd7, 8'hF0);
        wr(ENA, 8'h07);
        chk(pwm_out == 4'b0000, "R8 low one cycle after write", pwm_out, 0);
        @(negedge clk);
        chk(pwm_out == 4'b0111, "R8 high two cycles after write", pwm_out, 7);
        while (rises[2] < 2) @(negedge clk);
        chk(hi_len[0] == 1700, "R6 ch0 high time", hi_len[0], 1700);
        chk(per_len[0] == 17408, "R5 ch0 period", per_len[0], 17408);
        chk(falls[1] == 0 && pwm_out[1], "R6 ch1 full-on", falls[1], 0);
        chk(hi_len[2] == 32, "R6 ch2 single quantum", hi_len[2], 32);
        chk(per_len[2] == 32768, "R5 ch2 period", per_len[2], 32768);
        chk(rises[3] == 0 && !pwm_out[3], "R7 ch3 disabled low", rises[3], 0);

        // R9: mid-period update applies from the next period
        r = rises[0];
        while (rises[0] < r + 1) @(negedge clk);
        repeat (100) @(negedge clk);
        f = falls[0];
        wr(BASE + 8'd0, 8'd9);
        wr(BASE + 8'd1, 8'hE0);
        while (falls[0] < f + 1) @(negedge clk);
        chk(hi_len[0] == 1700, "R9 current high unchanged", hi_len[0], 1700);
        while (rises[0] < r + 2) @(negedge clk);
        chk(per_len[0] == 17408, "R9 current period unchanged", per_len[0], 17408);
        while (falls[0] < f + 2) @(negedge clk);
        chk(hi_len[0] == 180, "R9 new high time", hi_len[0], 180);
        while (rises[0] < r + 3) @(negedge clk);
        chk(per_len[0] == 18432, "R9 new period", per_len[0], 18432);

        // R7/R8: disable mid-high, restart fresh
        repeat (50) @(negedge clk);
        wr(ENA, 8'h06);
        chk(!pwm_out[0], "R7 forced low after clear", pwm_out[0], 0);
        chk(pwm_out[1], "R10 ch1 unaffected by ch0 clear", pwm_out[1], 1);
        repeat (30) @(negedge clk);
        chk(!pwm_out[0], "R7 stays low while disabled", pwm_out[0], 0);
        f = falls[0];
        wr(ENA, 8'h07);
        @(negedge clk);
        chk(pwm_out[0], "R8 restart high", pwm_out[0], 1);
        while (falls[0] < f + 1) @(negedge clk);
        chk(hi_len[0] == 180, "R7 counters reset full pulse", hi_len[0], 180);
        wr(ENA, 8'h05);
        chk(!pwm_out[1], "R7 ch1 forced low", pwm_out[1], 0);
        rd(ENA, v);
        chk(v == 8'h05, "R4 enable readback", v, 5);
        finish_run();
    end

endmodule